// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for a 128K-word by 16-bit static RAM as a memory controller sees it at the pins. It takes the usual active-low strobes: chip select, output enable, write enable, and one enable for each byte lane. From these it decides, on every system clock edge, whether the part is idle, has its outputs turned off, is being read, or is being written. The data bus is split into a 16-bit input, a 16-bit output and one drive-enable per byte lane. The wrapper that owns the real pads can use these to build a tri-state bus. A controller can therefore be checked in simulation or on an FPGA without a real memory device.

All strobes, the address and the write data are taken to be synchronous to `clk` and are sampled on its rising edge. Writes go into an internal array on that edge. Read data and lane drive-enables come from registers, so they show up one clock after the inputs that asked for them. The port keeps the full 17-bit address. The storage behind it holds only 2^STORE_AW words, and the address bits above that are ignored.

Top module: `sram_emu`

## Requirements
- R1: While `rst_n` is low, both bits of `dout_en` are 0, starting at the clock edge after the reset is applied at the latest.
- R2: A cycle sampled with `cs_n`=1 gives `dout_en`=00 on the next edge and changes no stored byte, whatever the other inputs are.
- R3: A cycle sampled with `cs_n`=0, `we_n`=1 and `oe_n`=1 gives `dout_en`=00 on the next edge.
- R4: A cycle sampled with `cs_n`=0 and both `lb_n` and `ub_n` at 1 gives `dout_en`=00 and stores nothing, whatever `we_n` and `oe_n` are.
- R5: A read cycle (`cs_n`=0, `we_n`=1, `oe_n`=0) sets `dout_en[0]`=~`lb_n` and `dout_en[1]`=~`ub_n` one edge later. Each driven lane of `dout` carries the byte stored at the sampled address.
- R6: A write cycle (`cs_n`=0, `we_n`=0, `oe_n` either level) stores `din[7:0]` when `lb_n`=0 and `din[15:8]` when `ub_n`=0. A lane whose enable is 1 keeps its old byte.
- R7: The edge after a write cycle always shows `dout_en`=00.
- R8: When write enable is held low over several edges with changing data, the value sampled on the last of those edges is the one kept.
- R9: `lb_n` and `dout_en[0]` govern bits 7:0. `ub_n` and `dout_en[1]` govern bits 15:8.
- R10: Only `addr[STORE_AW-1:0]` (default 10 bits) selects a word. Addresses that differ only above that bit reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| addr | input | 17 | Word address |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data toward the bus |
| dout_en | output | 2 | Per-lane drive enable, bit 0 lower byte, bit 1 upper byte |

## Verification
Random strobe combinations are mixed over a narrow address window that keeps hitting the same words. Every read is then compared with a byte-accurate model, so a lane swap, a lost write or a write that leaked through standby or with both byte enables high shows up as a data mismatch. Directed sequences add single-lane writes followed by full reads, which isolate the lane mapping. A write held over several edges with changing data separates last-value capture from first-value capture. A write with output enable low tells a correct write decode from one that lets output enable block writes. Finally, an access through an address that differs only in the high bits shows whether those bits are really ignored.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_HIZ   = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e            mode;
    logic [LANES-1:0] lane_sel;
  } access_t;
endpackage

// File: rtl/sram_emu_rst_sync.sv
module sram_emu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
  import sram_emu_pkg::*;
(
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [LANES-1:0] be_n,
  output access_t          acc
);
  always_comb begin
    acc.lane_sel = ~be_n;
    if (cs_n)            acc.mode = MODE_IDLE;
    else if (&be_n)      acc.mode = MODE_HIZ;
    else if (!we_n)      acc.mode = MODE_WRITE;
    else if (!oe_n)      acc.mode = MODE_READ;
    else                 acc.mode = MODE_HIZ;
  end
endmodule

// File: rtl/sram_emu_lane.sv
module sram_emu_lane #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          drive
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic          drive_q;
  logic          drive_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= mem[addr];
  end

  always_comb begin
    drive_d = rd_en & ~wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= drive_d;
  end

  assign dout  = rdata_q;
  assign drive = drive_q;

  // R7: a lane that was written never drives on the following edge
  a_r7_lane_quiet_after_write: assert property (
    @(posedge clk) disable iff (!rst_n) wr_en |=> !drive
  );
  // R5: a lane selected for a read drives on the following edge
  a_r5_lane_drives_after_read: assert property (
    @(posedge clk) disable iff (!rst_n) (rd_en && !wr_en) |=> drive
  );
endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int STORE_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  dout_en
);
  localparam int LANE_W = DATA_W / LANES;

  logic             rst_sync_n;
  access_t          acc;
  logic             is_write;
  logic             is_read;
  logic [STORE_AW-1:0] word_addr;

  sram_emu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_emu_decode u_decode (
    .cs_n (cs_n),
    .oe_n (oe_n),
    .we_n (we_n),
    .be_n ({ub_n, lb_n}),
    .acc  (acc)
  );

  always_comb begin
    is_write  = (acc.mode == MODE_WRITE);
    is_read   = (acc.mode == MODE_READ);
    word_addr = addr[STORE_AW-1:0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_emu_lane #(.DW(LANE_W), .AW(STORE_AW)) u_lane (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr_en (is_write & acc.lane_sel[g]),
      .rd_en (is_read & acc.lane_sel[g]),
      .addr  (word_addr),
      .din   (din[g*LANE_W +: LANE_W]),
      .dout  (dout[g*LANE_W +: LANE_W]),
      .drive (dout_en[g])
    );
  end

  // R1: reset keeps every lane off the bus
  a_r1_reset_quiet: assert property (
    @(posedge clk) !rst_n |-> (dout_en == '0)
  );
  // R2: a deselected cycle drives nothing next
  a_r2_standby_quiet: assert property (
    @(posedge clk) disable iff (!rst_sync_n) cs_n |=> (dout_en == '0)
  );
  // R3: output disabled drives nothing next
  a_r3_output_off: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
      (!cs_n && we_n && oe_n) |=> (dout_en == '0)
  );
  // R4: no byte enabled drives nothing next
  a_r4_no_lane: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
      (!cs_n && lb_n && ub_n) |=> (dout_en == '0)
  );
  // R7: a write cycle is followed by an undriven bus
  a_r7_write_undriven: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
      (!cs_n && !we_n) |=> (dout_en == '0)
  );
  // R9: the lane enables follow their own byte strobes on reads
  a_r9_lane_map: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
      (!cs_n && we_n && !oe_n) |=> (dout_en == ~$past({ub_n, lb_n}))
  );
endmodule

// File: tb/sram_emu_bench.sv
module sram_emu_bench;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int SAW = 10;
  localparam int WATCHDOG = 200000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, oe_n, we_n, lb_n, ub_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic [1:0]    dout_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] mdl [1 << SAW];
  logic [1:0]    vld [1 << SAW];

  bit            p_valid = 0;
  logic          p_cs, p_oe, p_we, p_lb, p_ub;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_din;
  string         p_tag;

  always #5ns clk = ~clk;

  sram_emu u_sram_emu (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [1:0] exp_en(logic c, logic o, logic w, logic l, logic u);
    return (!c && w && !o) ? {~u, ~l} : 2'b00;
  endfunction

  function automatic string mode_tag(logic c, logic o, logic w, logic l, logic u);
    if (c)           return "R2";
    else if (l && u) return "R4";
    else if (!w)     return "R7";
    else if (o)      return "R3";
    else             return "R5";
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_prev();
    logic [1:0] e;
    int idx;
    if (!p_valid) return;
    e = exp_en(p_cs, p_oe, p_we, p_lb, p_ub);
    check(dout_en === e, p_tag, {14'd0, dout_en}, {14'd0, e});
    idx = int'(p_addr[SAW-1:0]);
    for (int i = 0; i < 2; i++) begin
      if (e[i] && vld[idx][i])
        check(dout[i*8 +: 8] === mdl[idx][i*8 +: 8], p_tag,
              {8'd0, dout[i*8 +: 8]}, {8'd0, mdl[idx][i*8 +: 8]});
    end
    if (!p_cs && !p_we && !(p_lb && p_ub)) begin
      if (!p_lb) begin mdl[idx][7:0]  = p_din[7:0];  vld[idx][0] = 1'b1; end
      if (!p_ub) begin mdl[idx][15:8] = p_din[15:8]; vld[idx][1] = 1'b1; end
    end
  endtask

  task automatic op(logic c, logic o, logic w, logic l, logic u,
                    logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    @(negedge clk);
    check_prev();
    cs_n = c; oe_n = o; we_n = w; lb_n = l; ub_n = u; addr = a; din = d;
    p_cs = c; p_oe = o; p_we = w; p_lb = l; p_ub = u; p_addr = a; p_din = d;
    p_tag = tag; p_valid = 1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << SAW); i++) vld[i] = 2'b00;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    cs_n = 0; oe_n = 0; we_n = 1; lb_n = 0; ub_n = 0; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    check(dout_en === 2'b00, "R1", {14'd0, dout_en}, 16'd0);
    cs_n = 1;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 / R6: per-lane writes, then full and single-lane reads
    op(0, 1, 0, 1, 1, 17'h00010, 16'hFFFF, "R4");
    op(0, 1, 0, 0, 0, 17'h00010, 16'h1234, "R7");
    op(0, 0, 0, 0, 1, 17'h00010, 16'hAAAA, "R6");   // lower lane only, oe low
    op(0, 1, 0, 1, 0, 17'h00011, 16'h5566, "R7");   // upper lane only
    op(0, 0, 1, 0, 0, 17'h00010, 16'h0000, "R6");
    op(0, 0, 1, 1, 0, 17'h00010, 16'h0000, "R9");
    op(0, 0, 1, 0, 1, 17'h00010, 16'h0000, "R9");
    op(0, 0, 1, 1, 0, 17'h00011, 16'h0000, "R9");
    // R2 / R4: writes that must be ignored, checked by readback
    op(1, 0, 0, 0, 0, 17'h00010, 16'hDEAD, "R2");
    op(0, 0, 0, 1, 1, 17'h00010, 16'hBEEF, "R4");
    op(0, 0, 1, 0, 0, 17'h00010, 16'h0000, "R2");
    op(0, 1, 1, 0, 0, 17'h00010, 16'h0000, "R3");
    // R8: held write with changing data keeps the last sample
    op(0, 1, 0, 0, 0, 17'h00020, 16'h1111, "R7");
    op(0, 1, 0, 0, 0, 17'h00020, 16'h2222, "R7");
    op(0, 1, 0, 0, 0, 17'h00020, 16'h3333, "R7");
    op(0, 0, 1, 0, 0, 17'h00020, 16'h0000, "R8");
    // R10: high address bits alias onto the same word
    op(0, 1, 0, 0, 0, 17'h1F005, 16'hC0DE, "R7");
    op(0, 0, 1, 0, 0, 17'h00005, 16'h0000, "R10");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      logic [AW-1:0] a;
      logic c, o, w, l, u;
      r = $urandom;
      a = {r[31:25], 5'd0, r[4:0]};
      c = (r[7:5] == 3'd0);
      o = r[8]; w = r[9] & r[10]; l = r[11] & r[12]; u = r[13] & r[14];
      op(c, o, w, l, u, a, $urandom, mode_tag(c, o, w, l, u));
    end

    // R1: reset applied mid-run forces lanes off
    op(0, 0, 1, 0, 0, 17'h00010, 16'h0000, "R5");
    @(negedge clk);
    check_prev();
    p_valid = 0;
    rst_n = 1'b0;
    #1ns;
    check(dout_en === 2'b00, "R1", {14'd0, dout_en}, 16'd0);
    @(negedge clk);
    check(dout_en === 2'b00, "R1", {14'd0, dout_en}, 16'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule